// File: doc/BRIEF.md
# Dual-Channel Configurable Pulse Counter

This block is a single signed up/down counter fed by two input channels. Each channel has a pulse input and a control input. An edge of a pulse input is mapped by a per-channel table to an increment, a decrement or no change. The level of that channel's control input then either keeps the chosen direction or reverses it. The steps from both channels are summed and applied to the count in a single update. The count is bounded by programmable high and low limits and wraps to zero when an update would cross either limit.

Every input passes through a two-flop synchronizer. An optional glitch filter follows, shared by the whole unit. It accepts a new level only once that level has held for a programmable number of clock cycles. A level-sensitive run input gates counting, and a clear input forces the count to zero.

For 4x quadrature decoding, signal A is wired to channel 0's pulse input and channel 1's control input, and signal B to channel 0's control input and channel 1's pulse input. The table is then set up so that channel 0 counts down on rising edges and up on falling edges, channel 1 counts up on rising edges and down on falling edges, and the control-low level reverses the step. Every transition of A or B then moves the count by exactly one.

Top module: `pcnt_unit`

## Requirements
- R1: After reset, `count` is 0 and `lim_hit` is 0.
- R2: Each channel's edge action is a 2-bit code, with channel n in bits [2n+1:2n] of `rise_act` and `fall_act`: 01 adds one, 10 subtracts one, and 00 or 11 leave the count unchanged. `rise_act` applies to a rising pulse edge and `fall_act` to a falling one.
- R3: While channel n's control input is high, `ctrl_hi_inv[n]`=1 reverses the sign of that channel's step. While it is low, `ctrl_lo_inv[n]` does the same. A value of 0 keeps the step as it is.
- R4: When both channels produce a step in the same cycle, their sum (−2 to +2) is applied in one update.
- R5: If an update would make the count greater than `lim_hi`, the count becomes 0 and `lim_hit` is high for exactly one cycle.
- R6: If an update would make the count less than `lim_lo`, the count becomes 0 and `lim_hit` is high for exactly one cycle.
- R7: `clr` forces the count to 0 on the next clock edge and takes priority over any step in that cycle.
- R8: While `run` is low, the count holds its value. Edges that occur while stopped are discarded and are not applied when `run` returns high.
- R9: With `flt_en`=1 and `flt_thr`=T>0, a level on any input that lasts fewer than T clock cycles is ignored. A level that lasts T cycles or more is accepted.
- R10: With `flt_en`=0 or `flt_thr`=0, the synchronized inputs reach edge detection unfiltered, so a one-cycle pulse is counted.
- R11: Configured for quadrature as described above, one full forward cycle of A leading B adds 4 to the count, and one full reverse cycle subtracts 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Counting enabled while high |
| clr | input | 1 | Force count to zero |
| pulse_in | input | 2 | Pulse input per channel (asynchronous) |
| ctrl_in | input | 2 | Control input per channel (asynchronous) |
| rise_act | input | 4 | Rising-edge action code, 2 bits per channel |
| fall_act | input | 4 | Falling-edge action code, 2 bits per channel |
| ctrl_hi_inv | input | 2 | Per channel: reverse the step while control is high |
| ctrl_lo_inv | input | 2 | Per channel: reverse the step while control is low |
| flt_en | input | 1 | Glitch filter enable |
| flt_thr | input | 10 | Filter threshold in clock cycles |
| lim_hi | input | 16 | Signed high limit |
| lim_lo | input | 16 | Signed low limit |
| count | output | 16 | Signed count value |
| lim_hit | output | 1 | One-cycle pulse when a limit wrap occurs |

## Verification
The hardest situation to reach from the ports is a filter decision made exactly at the threshold. A pulse one cycle shorter than the threshold must leave the count unchanged, while a pulse of exactly the threshold length must move it. The stimulus drives pulses whose widths are counted in whole clock periods, with changes made on the falling edge, so that the synchronizer delay is the same for both edges of each pulse. A second hard case is a single update that combines steps from both channels, which needs both pulse inputs to change on the same clock edge. The bench drives both pulse inputs at the same falling edge to produce it.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_UP   = 2'b01,
        ACT_DOWN = 2'b10,
        ACT_NONE = 2'b11
    } edge_act_e;

    typedef struct packed {
        edge_act_e on_rise;
        edge_act_e on_fall;
        logic      inv_hi;
        logic      inv_lo;
    } chan_cfg_t;

    function automatic logic signed [1:0] step_of(edge_act_e act, logic invert);
        logic signed [1:0] s;
        case (act)
            ACT_UP:   s = invert ? -2'sd1 : 2'sd1;
            ACT_DOWN: s = invert ? 2'sd1 : -2'sd1;
            default:  s = 2'sd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pcnt_in_cond.sv
module pcnt_in_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int THR_W       = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic             flt_en,
    input  logic [THR_W-1:0] flt_thr,
    output logic             dout
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   bypass;
    logic                   stable_q;
    logic [THR_W-1:0]       run_q;
    logic [THR_W:0]         run_next;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign synced   = sync_q[SYNC_STAGES-1];
    assign bypass   = !flt_en || (flt_thr == '0);
    assign run_next = {1'b0, run_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stable_q <= 1'b0;
            run_q    <= '0;
        end else if (bypass) begin
            stable_q <= synced;
            run_q    <= '0;
        end else if (synced == stable_q) begin
            run_q    <= '0;
        end else if (run_next >= {1'b0, flt_thr}) begin
            stable_q <= synced;
            run_q    <= '0;
        end else begin
            run_q    <= run_next[THR_W-1:0];
        end
    end

    assign dout = bypass ? synced : stable_q;
endmodule

// File: rtl/pcnt_chan.sv
module pcnt_chan
    import pcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_f,
    input  logic              ctrl_f,
    input  chan_cfg_t         cfg,
    output logic signed [1:0] step
);
    logic      prev_q;
    logic      rise;
    logic      fall;
    edge_act_e act;
    logic      invert;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pulse_f;
    end

    assign rise   = pulse_f & ~prev_q;
    assign fall   = ~pulse_f & prev_q;
    assign act    = rise ? cfg.on_rise : (fall ? cfg.on_fall : ACT_HOLD);
    assign invert = ctrl_f ? cfg.inv_hi : cfg.inv_lo;
    assign step   = step_of(act, invert);
endmodule

// File: rtl/pcnt_core.sv
module pcnt_core #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic                    clr,
    input  logic signed [NCH*2-1:0] steps,
    input  logic signed [CNT_W-1:0] lim_hi,
    input  logic signed [CNT_W-1:0] lim_lo,
    output logic signed [CNT_W-1:0] count,
    output logic                    lim_hit
);
    localparam int SUM_W = $clog2(NCH + 1) + 2;

    logic signed [SUM_W-1:0] delta;
    logic signed [CNT_W:0]   nxt;

    always_comb begin
        delta = '0;
        for (int i = 0; i < NCH; i++) begin
            delta = delta + SUM_W'($signed(steps[2*i +: 2]));
        end
    end

    assign nxt = (CNT_W+1)'(count) + (CNT_W+1)'(delta);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count   <= '0;
            lim_hit <= 1'b0;
        end else if (run && delta != '0) begin
            if (nxt > (CNT_W+1)'(lim_hi) || nxt < (CNT_W+1)'(lim_lo)) begin
                count   <= '0;
                lim_hit <= 1'b1;
            end else begin
                count   <= nxt[CNT_W-1:0];
                lim_hit <= 1'b0;
            end
        end else begin
            lim_hit <= 1'b0;
        end
    end
endmodule

// File: rtl/pcnt_unit.sv
module pcnt_unit
    import pcnt_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int CNT_W       = 16,
    parameter int THR_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic                    clr,
    input  logic [NCH-1:0]          pulse_in,
    input  logic [NCH-1:0]          ctrl_in,
    input  logic [2*NCH-1:0]        rise_act,
    input  logic [2*NCH-1:0]        fall_act,
    input  logic [NCH-1:0]          ctrl_hi_inv,
    input  logic [NCH-1:0]          ctrl_lo_inv,
    input  logic                    flt_en,
    input  logic [THR_W-1:0]        flt_thr,
    input  logic signed [CNT_W-1:0] lim_hi,
    input  logic signed [CNT_W-1:0] lim_lo,
    output logic signed [CNT_W-1:0] count,
    output logic                    lim_hit
);
    localparam int NSIG = 2 * NCH;

    logic [NSIG-1:0]          raw_sig;
    logic [NSIG-1:0]          flt_sig;
    logic signed [2*NCH-1:0]  steps;

    assign raw_sig = {ctrl_in, pulse_in};

    for (genvar s = 0; s < NSIG; s++) begin : g_cond
        pcnt_in_cond #(.SYNC_STAGES(SYNC_STAGES), .THR_W(THR_W)) u_cond (
            .clk(clk), .rst(rst), .din(raw_sig[s]),
            .flt_en(flt_en), .flt_thr(flt_thr), .dout(flt_sig[s])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_cfg_t         cfg;
        logic signed [1:0] st;
        assign cfg.on_rise = edge_act_e'(rise_act[2*c +: 2]);
        assign cfg.on_fall = edge_act_e'(fall_act[2*c +: 2]);
        assign cfg.inv_hi  = ctrl_hi_inv[c];
        assign cfg.inv_lo  = ctrl_lo_inv[c];
        pcnt_chan u_chan (
            .clk(clk), .rst(rst), .pulse_f(flt_sig[c]),
            .ctrl_f(flt_sig[NCH + c]), .cfg(cfg), .step(st)
        );
        assign steps[2*c +: 2] = st;
    end

    pcnt_core #(.CNT_W(CNT_W), .NCH(NCH)) u_core (
        .clk(clk), .rst(rst), .run(run), .clr(clr), .steps(steps),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .count(count), .lim_hit(lim_hit)
    );
endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker #(
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    run,
    input logic                    clr,
    input logic signed [CNT_W-1:0] count,
    input logic                    lim_hit
);
    logic signed [CNT_W-1:0] prev_cnt;
    logic                    prev_clr;
    logic signed [CNT_W:0]   diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cnt <= '0;
            prev_clr <= 1'b0;
        end else begin
            prev_cnt <= count;
            prev_clr <= clr;
        end
    end

    assign diff = (CNT_W+1)'(count) - (CNT_W+1)'(prev_cnt);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && !lim_hit));

    assert_step_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (!prev_clr && !lim_hit) |-> (diff >= -2 && diff <= 2));

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
        lim_hit |-> count == '0);

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && !lim_hit));

    assert_hold_stopped_R8: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> (count == $past(count) && !lim_hit));
endmodule

bind pcnt_unit pcnt_checker #(.CNT_W(CNT_W)) u_pcnt_chk (
    .clk(clk), .rst(rst), .run(run), .clr(clr),
    .count(count), .lim_hit(lim_hit)
);

// File: tb/tb_pcnt_unit.sv
module tb_pcnt_unit;
    logic               clk = 1'b0;
    logic               rst;
    logic               run, clr;
    logic [1:0]         pulse_in, ctrl_in;
    logic [3:0]         rise_act, fall_act;
    logic [1:0]         ctrl_hi_inv, ctrl_lo_inv;
    logic               flt_en;
    logic [9:0]         flt_thr;
    logic signed [15:0] lim_hi, lim_lo;
    logic signed [15:0] count;
    logic               lim_hit;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcnt_unit dut (
        .clk(clk), .rst(rst), .run(run), .clr(clr),
        .pulse_in(pulse_in), .ctrl_in(ctrl_in),
        .rise_act(rise_act), .fall_act(fall_act),
        .ctrl_hi_inv(ctrl_hi_inv), .ctrl_lo_inv(ctrl_lo_inv),
        .flt_en(flt_en), .flt_thr(flt_thr),
        .lim_hi(lim_hi), .lim_lo(lim_lo),
        .count(count), .lim_hit(lim_hit)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one pulse input, then wait until the resulting update is visible.
    task automatic set_pulse(int ch, logic v);
        pulse_in[ch] = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_default();
        run = 1'b1; clr = 1'b0;
        rise_act = 4'b00_01; fall_act = 4'b00_00;
        ctrl_hi_inv = 2'b00; ctrl_lo_inv = 2'b00;
        flt_en = 1'b0; flt_thr = 10'd5;
        lim_hi = 16'sd32767; lim_lo = -16'sd32768;
        pulse_in = 2'b00; ctrl_in = 2'b00;
        cycles(4);
        clr = 1'b1; cycles(1); clr = 1'b0; cycles(1);
        exp_cnt = 0;
    endtask

    task automatic t_reset();
        chk("R1 count after reset", count, 0);
        chk("R1 lim_hit after reset", lim_hit, 0);
    endtask

    task automatic t_edge_actions();
        cfg_default();
        set_pulse(0, 1'b1); exp_cnt++;
        chk("R2 rise up", count, exp_cnt);
        set_pulse(0, 1'b0);
        chk("R2 fall hold", count, exp_cnt);
        fall_act[1:0] = 2'b10;
        set_pulse(0, 1'b1); exp_cnt++;
        set_pulse(0, 1'b0); exp_cnt--;
        chk("R2 fall down", count, exp_cnt);
        rise_act[1:0] = 2'b11;
        set_pulse(0, 1'b1);
        chk("R2 code 11 holds", count, exp_cnt);
    endtask

    task automatic t_level();
        cfg_default();
        ctrl_hi_inv[0] = 1'b1;
        ctrl_in[0] = 1'b1; cycles(4);
        set_pulse(0, 1'b1); exp_cnt--;
        chk("R3 high level inverts", count, exp_cnt);
        set_pulse(0, 1'b0);
        ctrl_in[0] = 1'b0; cycles(4);
        set_pulse(0, 1'b1); exp_cnt++;
        chk("R3 low level keeps", count, exp_cnt);
    endtask

    task automatic t_dual();
        cfg_default();
        rise_act = 4'b01_01;
        pulse_in[0] = 1'b1;
        set_pulse(1, 1'b1); exp_cnt += 2;
        chk("R4 both up in one update", count, exp_cnt);
        rise_act = 4'b10_10;
        pulse_in = 2'b00; cycles(4);
        pulse_in[0] = 1'b1;
        set_pulse(1, 1'b1); exp_cnt -= 2;
        chk("R4 both down in one update", count, exp_cnt);
    endtask

    task automatic t_high_wrap();
        cfg_default();
        lim_hi = 16'sd3;
        fall_act[1:0] = 2'b01;
        set_pulse(0, 1'b1);
        set_pulse(0, 1'b0);
        set_pulse(0, 1'b1);
        chk("R5 reaches limit", count, 3);
        chk("R5 no hit at limit", lim_hit, 0);
        set_pulse(0, 1'b0);
        chk("R5 wrap to zero", count, 0);
        chk("R5 hit pulse", lim_hit, 1);
        cycles(1);
        chk("R5 hit one cycle", lim_hit, 0);
    endtask

    task automatic t_low_wrap();
        cfg_default();
        lim_lo = -16'sd2;
        rise_act[1:0] = 2'b10;
        set_pulse(0, 1'b1);
        set_pulse(0, 1'b0);
        set_pulse(0, 1'b1);
        chk("R6 reaches low limit", count, -2);
        set_pulse(0, 1'b0);
        set_pulse(0, 1'b1);
        chk("R6 wrap to zero", count, 0);
        chk("R6 hit pulse", lim_hit, 1);
        cycles(1);
        chk("R6 hit one cycle", lim_hit, 0);
    endtask

    task automatic t_clear();
        cfg_default();
        set_pulse(0, 1'b1);
        chk("R7 before clear", count, 1);
        clr = 1'b1; cycles(1); clr = 1'b0;
        chk("R7 clear to zero", count, 0);
        pulse_in[0] = 1'b0; cycles(4);
        clr = 1'b1;
        pulse_in[0] = 1'b1; cycles(5);
        clr = 1'b0; cycles(3);
        chk("R7 clear beats step", count, 0);
    endtask

    task automatic t_run();
        cfg_default();
        set_pulse(0, 1'b1); exp_cnt++;
        run = 1'b0;
        set_pulse(0, 1'b0);
        set_pulse(0, 1'b1);
        chk("R8 stopped holds", count, exp_cnt);
        run = 1'b1; cycles(4);
        chk("R8 no stale edge", count, exp_cnt);
        set_pulse(0, 1'b0);
        set_pulse(0, 1'b1); exp_cnt++;
        chk("R8 resumes", count, exp_cnt);
    endtask

    task automatic t_filter();
        cfg_default();
        flt_en = 1'b1; flt_thr = 10'd5; cycles(4);
        pulse_in[0] = 1'b1; cycles(4); pulse_in[0] = 1'b0; cycles(20);
        chk("R9 short pulse ignored", count, exp_cnt);
        pulse_in[0] = 1'b1; cycles(5); pulse_in[0] = 1'b0; cycles(20);
        exp_cnt++;
        chk("R9 threshold pulse counted", count, exp_cnt);
    endtask

    task automatic t_bypass();
        cfg_default();
        flt_en = 1'b1; flt_thr = 10'd0; cycles(2);
        pulse_in[0] = 1'b1; cycles(1); pulse_in[0] = 1'b0; cycles(6);
        exp_cnt++;
        chk("R10 zero threshold passes", count, exp_cnt);
        flt_en = 1'b0; flt_thr = 10'd5; cycles(2);
        pulse_in[0] = 1'b1; cycles(1); pulse_in[0] = 1'b0; cycles(6);
        exp_cnt++;
        chk("R10 disabled filter passes", count, exp_cnt);
    endtask

    task automatic quad_ab(logic a, logic b);
        pulse_in[0] = a; ctrl_in[1] = a;
        pulse_in[1] = b; ctrl_in[0] = b;
        cycles(5);
    endtask

    task automatic t_quad();
        cfg_default();
        rise_act = 4'b01_10; fall_act = 4'b10_01;
        ctrl_hi_inv = 2'b00; ctrl_lo_inv = 2'b11;
        cycles(2);
        quad_ab(1, 0); chk("R11 first step", count, 1);
        quad_ab(1, 1); quad_ab(0, 1); quad_ab(0, 0);
        chk("R11 forward cycle", count, 4);
        quad_ab(0, 1); quad_ab(1, 1); quad_ab(1, 0); quad_ab(0, 0);
        chk("R11 reverse cycle", count, 0);
        quad_ab(0, 1); quad_ab(1, 1); quad_ab(1, 0); quad_ab(0, 0);
        chk("R11 reverse again", count, -4);
    endtask

    initial begin
        rst = 1'b1;
        run = 1'b0; clr = 1'b0;
        pulse_in = 2'b00; ctrl_in = 2'b00;
        rise_act = 4'b0; fall_act = 4'b0;
        ctrl_hi_inv = 2'b0; ctrl_lo_inv = 2'b0;
        flt_en = 1'b0; flt_thr = 10'd5;
        lim_hi = 16'sd32767; lim_lo = -16'sd32768;
        cycles(4);
        rst = 1'b0;
        cycles(1);
        t_reset();
        t_edge_actions();
        t_level();
        t_dual();
        t_high_wrap();
        t_low_wrap();
        t_clear();
        t_run();
        t_filter();
        t_bypass();
        t_quad();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule